// File: doc/BRIEF.md
# Receive Byte-to-Word SRAM Writer

This block runs on the core clock and empties a byte-wide receive queue into a circular receive region of a 32-bit wide SRAM. The region is a window of whole SRAM words between a programmable first word and last word. Incoming bytes are staged in a word register and committed to the SRAM. A complete, aligned word goes out as one plain write. A partial word goes out as a read-modify-write, either because the stream paused or because the word started mid-way.

The block owns the write pointer, and software owns the read pointer. Both are byte offsets from the start of the window, with one extra most-significant bit that flips every time the offset wraps. From the two pointers the block derives the buffered amount. It raises a full flag when no byte can be added, and it drops bytes that arrive while full with a one-cycle overflow pulse. It also raises a level flag when the committed amount exceeds a programmable threshold.

The SRAM port is a plain single-cycle port. Read data appears on the cycle after a read request and holds until the next read.

Top module: `rx_word_packer`

## Requirements
- R1: A word whose four lanes are all filled starting at byte lane 0 is committed with a single SRAM write and no SRAM read. The first byte received goes in bits 7:0 and the fourth in bits 31:24.
- R2: While a partial word is staged and the queue is empty, nothing is written until `timer_i` consecutive core cycles have passed without an accepted byte. The partial word is then flushed within three further cycles.
- R3: A partial word is flushed as a read of the target word, followed on the next cycle by a write to the same address. Lanes that hold no staged byte keep their old SRAM contents.
- R4: The SRAM word address is `base_i` plus the write-pointer offset bits [SramAw+1:2]. It always lies between `base_i` and `limit_i`.
- R5: The write pointer is bit [SramAw+2] = phase, bits [SramAw+1:0] = byte offset, with the low 2 bits as the byte lane. It advances by the number of bytes committed, after their write. It wraps to 0 at region size (`limit_i` − `base_i` + 1) × 4 bytes, and the phase toggles on wrap.
- R6: The buffered amount is offset_w − offset_r if the phases match, and otherwise size − offset_r + offset_w. `full_o` is high when the buffered amount plus the staged bytes equals the size. A byte popped while full is discarded and never written. In that case `overflow_o` is high for that cycle and the write pointer does not move for it.
- R7: `level_o` is high exactly when the committed buffered amount is strictly greater than `level_i`.
- R8: After reset the write pointer is 0, and `full_o`, `overflow_o`, `level_o`, `fifo_pop_o` and `sram_req_o` are low.
- R9: `fifo_pop_o` is asserted only while `fifo_valid_i` is high, and each pop consumes exactly one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fifo_valid_i | input | 1 | Receive queue holds a byte |
| fifo_data_i | input | 8 | Byte at the head of the receive queue |
| fifo_pop_o | output | 1 | Consume the head byte this cycle |
| base_i | input | SramAw | First SRAM word of the receive region |
| limit_i | input | SramAw | Last SRAM word of the receive region |
| rptr_i | input | SramAw+3 | Software read pointer (phase + byte offset) |
| level_i | input | SramAw+3 | Threshold for the level flag |
| timer_i | input | TmrW | Idle cycles before a partial word is flushed |
| sram_req_o | output | 1 | SRAM access request |
| sram_we_o | output | 1 | Write (1) or read (0) |
| sram_addr_o | output | SramAw | SRAM word address |
| sram_wdata_o | output | 32 | SRAM write data |
| sram_rdata_i | input | 32 | SRAM read data, valid the cycle after a read |
| wptr_o | output | SramAw+3 | Hardware write pointer (phase + byte offset) |
| full_o | output | 1 | Region cannot take another byte |
| level_o | output | 1 | Committed amount above threshold |
| overflow_o | output | 1 | Byte discarded this cycle |

## Verification
The bench targets a partial word that starts mid-word, so that the merge must keep lanes written by an earlier flush. A design that skipped the read or used the wrong mask would wipe those bytes. It measures the gap between the last accepted byte and the first SRAM access against the idle timeout; an early flush shows up as a gap that is too short, and a missing flush as a missing write. It drives small windows offset from word 0 until they fill and wrap. A wrong wrap point, a phase bit that never flips, or an off-by-one full test would then write outside the window, over unread data, or count the wrong number of dropped bytes. Random bursts with random timeouts and random software catch-up are checked against a byte-level model of the memory and both pointers.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  localparam int unsigned WordW  = 32;
  localparam int unsigned ByteW  = 8;
  localparam int unsigned NLanes = WordW / ByteW;
  localparam int unsigned LaneW  = $clog2(NLanes);
  localparam int unsigned CntW   = LaneW + 1;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_ADV   = 3'd4
  } rxw_state_e;
endpackage

// File: rtl/rxw_lane_merge.sv
module rxw_lane_merge
  import rxw_pkg::*;
(
  input  logic [WordW-1:0]  old_i,
  input  logic [WordW-1:0]  new_i,
  input  logic [NLanes-1:0] mask_i,
  output logic [WordW-1:0]  out_o
);
  for (genvar k = 0; k < NLanes; k++) begin : g_lane
    assign out_o[k*ByteW +: ByteW] = mask_i[k] ? new_i[k*ByteW +: ByteW]
                                               : old_i[k*ByteW +: ByteW];
  end
endmodule

// File: rtl/rxw_idle_timer.sv
module rxw_idle_timer #(
  parameter int unsigned TmrW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            clr_i,
  input  logic [TmrW-1:0] limit_i,
  output logic            expired_o
);
  logic [TmrW-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  assign expired_o = (cnt_q == limit_i);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clr_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (run_i && !expired_o) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + TmrW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R2: a cleared timer starts the idle window from zero
  a_r2_clear_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/rxw_ptr_unit.sv
module rxw_ptr_unit
  import rxw_pkg::*;
#(
  parameter int unsigned SramAw = 9,
  localparam int unsigned OffW  = SramAw + 2,
  localparam int unsigned PtrW  = OffW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SramAw-1:0] base_i,
  input  logic [SramAw-1:0] limit_i,
  input  logic [PtrW-1:0]   rptr_i,
  input  logic [PtrW-1:0]   level_i,
  input  logic              adv_i,
  input  logic [CntW-1:0]   adv_bytes_i,
  input  logic [CntW-1:0]   staged_i,
  output logic [PtrW-1:0]   wptr_o,
  output logic              full_o,
  output logic              level_o
);
  logic [PtrW-1:0]   wptr_q, wptr_d;
  logic [SramAw:0]   words;
  logic [OffW:0]     size;
  logic [OffW:0]     w_off, r_off, depth, sum;
  logic              w_ph, r_ph;
  logic [OffW+1:0]   occupied;

  assign words = {1'b0, limit_i} - {1'b0, base_i} + (SramAw+1)'(1);
  assign size  = {words, 2'b00};
  assign w_off = {1'b0, wptr_q[OffW-1:0]};
  assign r_off = {1'b0, rptr_i[OffW-1:0]};
  assign w_ph  = wptr_q[OffW];
  assign r_ph  = rptr_i[OffW];

  always_comb begin
    if (w_ph == r_ph) depth = w_off - r_off;
    else              depth = size - r_off + w_off;
  end

  assign occupied = {1'b0, depth} + (OffW+2)'(staged_i);
  assign full_o   = occupied >= {1'b0, size};
  assign level_o  = depth > level_i;

  always_comb begin
    sum    = w_off + (OffW+1)'(adv_bytes_i);
    wptr_d = wptr_q;
    if (sum >= size) begin
      wptr_d = {~w_ph, OffW'(sum - size)};
    end else begin
      wptr_d = {w_ph, sum[OffW-1:0]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
    end else if (adv_i) begin
      wptr_q <= wptr_d;
    end
  end

  assign wptr_o = wptr_q;

  // R5: the pointer only moves in the advance step
  a_r5_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(wptr_q));
endmodule

// File: rtl/rx_word_packer.sv
module rx_word_packer
  import rxw_pkg::*;
#(
  parameter int unsigned SramAw = 9,
  parameter int unsigned TmrW   = 8,
  localparam int unsigned OffW  = SramAw + 2,
  localparam int unsigned PtrW  = OffW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_valid_i,
  input  logic [ByteW-1:0]  fifo_data_i,
  output logic              fifo_pop_o,
  input  logic [SramAw-1:0] base_i,
  input  logic [SramAw-1:0] limit_i,
  input  logic [PtrW-1:0]   rptr_i,
  input  logic [PtrW-1:0]   level_i,
  input  logic [TmrW-1:0]   timer_i,
  output logic              sram_req_o,
  output logic              sram_we_o,
  output logic [SramAw-1:0] sram_addr_o,
  output logic [WordW-1:0]  sram_wdata_o,
  input  logic [WordW-1:0]  sram_rdata_i,
  output logic [PtrW-1:0]   wptr_o,
  output logic              full_o,
  output logic              level_o,
  output logic              overflow_o
);
  rxw_state_e        state_q, state_d;
  logic [WordW-1:0]  stage_q, stage_d;
  logic [CntW-1:0]   cnt_q, cnt_d;
  logic              rmw_q, rmw_d;
  logic              stage_en, rmw_en;
  logic [PtrW-1:0]   wptr;
  logic [LaneW-1:0]  lane;
  logic [CntW-1:0]   pos;
  logic [NLanes-1:0] mask;
  logic [WordW-1:0]  merged;
  logic              accept, keep, drop, word_fill;
  logic              tmr_run, tmr_clr, tmr_exp;

  assign lane      = wptr[LaneW-1:0];
  assign pos       = {1'b0, lane} + cnt_q;
  assign accept    = fifo_valid_i && (state_q == ST_IDLE || state_q == ST_WAIT);
  assign keep      = accept && !full_o;
  assign drop      = accept && full_o;
  assign word_fill = (pos == CntW'(NLanes - 1));

  for (genvar k = 0; k < NLanes; k++) begin : g_mask
    assign mask[k] = (CntW'(k) >= {1'b0, lane}) && (CntW'(k) < pos);
  end

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_WAIT: begin
        if (keep) begin
          if (word_fill) state_d = (lane == '0) ? ST_WRITE : ST_READ;
          else           state_d = ST_WAIT;
        end else if (state_q == ST_WAIT && tmr_exp) begin
          state_d = ST_READ;
        end
      end
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: state_d = ST_ADV;
      ST_ADV:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // staging data path
  always_comb begin
    stage_en = 1'b0;
    stage_d  = stage_q;
    cnt_d    = cnt_q;
    if (state_q == ST_ADV) begin
      stage_en = 1'b1;
      stage_d  = '0;
      cnt_d    = '0;
    end else if (keep) begin
      stage_en = 1'b1;
      cnt_d    = cnt_q + CntW'(1);
      for (int k = 0; k < NLanes; k++) begin
        if (pos[LaneW-1:0] == LaneW'(k)) stage_d[k*ByteW +: ByteW] = fifo_data_i;
      end
    end
  end

  always_comb begin
    rmw_en = 1'b0;
    rmw_d  = rmw_q;
    if (state_q == ST_READ) begin
      rmw_en = 1'b1;
      rmw_d  = 1'b1;
    end else if (state_q == ST_ADV) begin
      rmw_en = 1'b1;
      rmw_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      stage_q <= '0;
      cnt_q   <= '0;
      rmw_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (stage_en) begin
        stage_q <= stage_d;
        cnt_q   <= cnt_d;
      end
      if (rmw_en) rmw_q <= rmw_d;
    end
  end

  assign tmr_run = (state_q == ST_WAIT) && !keep;
  assign tmr_clr = keep || (state_q != ST_WAIT);

  rxw_idle_timer #(.TmrW(TmrW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (tmr_run),
    .clr_i     (tmr_clr),
    .limit_i   (timer_i),
    .expired_o (tmr_exp)
  );

  rxw_ptr_unit #(.SramAw(SramAw)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .base_i      (base_i),
    .limit_i     (limit_i),
    .rptr_i      (rptr_i),
    .level_i     (level_i),
    .adv_i       (state_q == ST_ADV),
    .adv_bytes_i (cnt_q),
    .staged_i    (cnt_q),
    .wptr_o      (wptr),
    .full_o      (full_o),
    .level_o     (level_o)
  );

  rxw_lane_merge u_merge (
    .old_i  (sram_rdata_i),
    .new_i  (stage_q),
    .mask_i (mask),
    .out_o  (merged)
  );

  assign fifo_pop_o   = accept;
  assign overflow_o   = drop;
  assign sram_req_o   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign sram_we_o    = (state_q == ST_WRITE);
  assign sram_addr_o  = base_i + wptr[OffW-1:LaneW];
  assign sram_wdata_o = rmw_q ? merged : stage_q;
  assign wptr_o       = wptr;

  // R9: never pop an empty queue
  a_r9_pop_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> fifo_valid_i);

  // R3: a read is followed by a write to the same word
  a_r3_read_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_req_o && !sram_we_o) |=> (sram_req_o && sram_we_o && sram_addr_o == $past(sram_addr_o)));

  // R1: a write without a preceding read carries a whole aligned word
  a_r1_plain_write_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_req_o && sram_we_o && !rmw_q) |-> (lane == '0 && cnt_q == CntW'(NLanes)));

  // R4: accesses stay inside the window
  a_r4_addr_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_req_o |-> (sram_addr_o >= base_i && sram_addr_o <= limit_i));

  // R6: a discarded byte is only popped while full
  a_r6_drop_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> (fifo_pop_o && full_o));
endmodule

// File: tb/rx_word_packer_tb_top.sv
`timescale 1ns/1ps
module rx_word_packer_tb_top;
  localparam int AW = 9;
  localparam int PW = AW + 3;
  localparam int OW = AW + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fifo_valid, fifo_pop, sram_req, sram_we;
  logic [7:0]    fifo_data;
  logic [AW-1:0] base, limit, sram_addr;
  logic [PW-1:0] rptr, level, wptr;
  logic [7:0]    timer;
  logic [31:0]   sram_wdata, sram_rdata;
  logic          full, lvl, ovf;

  always #2 clk = ~clk;

  rx_word_packer #(.SramAw(AW), .TmrW(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .fifo_valid_i(fifo_valid), .fifo_data_i(fifo_data), .fifo_pop_o(fifo_pop),
    .base_i(base), .limit_i(limit), .rptr_i(rptr), .level_i(level), .timer_i(timer),
    .sram_req_o(sram_req), .sram_we_o(sram_we), .sram_addr_o(sram_addr),
    .sram_wdata_o(sram_wdata), .sram_rdata_i(sram_rdata),
    .wptr_o(wptr), .full_o(full), .level_o(lvl), .overflow_o(ovf)
  );

  // queue model
  logic [7:0] fq [0:4095];
  int head = 0;
  int tail = 0;
  assign fifo_valid = (head != tail);
  assign fifo_data  = fq[head[11:0]];

  // SRAM model and activity counters
  logic [31:0] mem [0:(1<<AW)-1];
  logic [31:0] exp_mem [0:(1<<AW)-1];
  int n_rd, n_wr, n_ovf, cyc, last_pop, first_req;
  bit got_req;

  function automatic logic [31:0] f_fill(int i);
    return 32'hA5000000 ^ (i * 32'h00010203);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < (1<<AW); i++) mem[i] <= f_fill(i);
      sram_rdata <= '0;
      head <= tail;
      n_rd <= 0; n_wr <= 0; n_ovf <= 0; cyc <= 0;
      last_pop <= 0; first_req <= 0; got_req <= 1'b0;
    end else begin
      cyc <= cyc + 1;
      if (sram_req && sram_we)  begin mem[sram_addr] <= sram_wdata; n_wr <= n_wr + 1; end
      if (sram_req && !sram_we) begin sram_rdata <= mem[sram_addr]; n_rd <= n_rd + 1; end
      if (fifo_pop) begin head <= head + 1; last_pop <= cyc; got_req <= 1'b0; end
      else if (sram_req && !got_req) begin got_req <= 1'b1; first_req <= cyc; end
      if (ovf) n_ovf <= n_ovf + 1;
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int exp_woff, exp_drop;
  bit exp_wph;

  task automatic chk(bit ok, string tag, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic int f_size();
    return (int'(limit) - int'(base) + 1) * 4;
  endfunction

  function automatic int f_depth(bit wph, int woff, logic [PW-1:0] rp, int sz);
    int roff = int'(rp[OW-1:0]);
    if (wph == rp[OW]) return woff - roff;
    return sz - roff + woff;
  endfunction

  task automatic do_reset(int b, int l);
    rst_n = 1'b0;
    base = AW'(b); limit = AW'(l);
    rptr = '0; level = PW'(12'h080); timer = 8'd8;
    for (int i = 0; i < (1<<AW); i++) exp_mem[i] = f_fill(i);
    exp_woff = 0; exp_wph = 0; exp_drop = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(logic [7:0] b);
    int sz = f_size();
    fq[tail[11:0]] = b;
    tail++;
    if (f_depth(exp_wph, exp_woff, rptr, sz) >= sz) exp_drop++;
    else begin
      exp_mem[int'(base) + exp_woff/4][(exp_woff%4)*8 +: 8] = b;
      exp_woff++;
      if (exp_woff == sz) begin exp_woff = 0; exp_wph = ~exp_wph; end
    end
  endtask

  task automatic push_burst(int n);
    for (int i = 0; i < n; i++) begin
      push(8'($urandom));
      @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (int'(timer) + 30) @(negedge clk);
  endtask

  task automatic check_mem(string tag);
    int bad = 0;
    int where = 0;
    for (int i = 0; i < (1<<AW); i++)
      if (mem[i] !== exp_mem[i]) begin if (bad == 0) where = i; bad++; end
    chk(bad == 0, tag, (bad == 0) ? 0 : mem[where], (bad == 0) ? 0 : exp_mem[where]);
  endtask

  function automatic logic [PW-1:0] exp_wptr();
    return {exp_wph, OW'(exp_woff)};
  endfunction

  initial begin
    void'($urandom(32'h5EED_0042));
    base = '0; limit = '0; rptr = '0; level = '0; timer = '0;
    do_reset(0, 127);

    // R8 reset state
    chk(wptr == '0, "R8 wptr after reset", wptr, 0);
    chk(!full && !ovf && !lvl, "R8 flags after reset", {full, ovf, lvl}, 0);
    chk(!sram_req && !fifo_pop, "R8 no activity after reset", {sram_req, fifo_pop}, 0);

    // R1: two aligned full words, no reads
    push_burst(8);
    settle();
    chk(n_wr == 2, "R1 full-word write count", n_wr, 2);
    chk(n_rd == 0, "R1 no read for full words", n_rd, 0);
    check_mem("R1 word contents and lane order");
    chk(wptr == exp_wptr(), "R5 wptr after 8 bytes", wptr, exp_wptr());

    // R2/R3: partial word of three bytes, timeout 20
    timer = 8'd20;
    @(negedge clk);
    push_burst(3);
    settle();
    chk(first_req - last_pop >= 21 && first_req - last_pop <= 23,
        "R2 flush gap after idle timeout", first_req - last_pop, 22);
    chk(n_rd == 1 && n_wr == 3, "R3 one read-modify-write", {n_rd[15:0], n_wr[15:0]}, 32'h00010003);
    check_mem("R3 untouched lane kept");
    chk(wptr == exp_wptr(), "R5 wptr after partial", wptr, exp_wptr());

    // R3: single byte finishing the word mid-way keeps earlier lanes
    push_burst(1);
    settle();
    chk(n_rd == 2, "R3 mid-word completion merges", n_rd, 2);
    check_mem("R3 earlier lanes preserved");
    chk(wptr == exp_wptr(), "R5 wptr after mid-word fill", wptr, exp_wptr());
    chk(lvl == 1'b0, "R7 level low below threshold", lvl, 0);

    // R4/R5/R6: small offset window, fill and overflow
    do_reset(16, 19);
    push_burst(20);
    settle();
    chk(n_ovf == 4 && exp_drop == 4, "R6 four bytes dropped", n_ovf, 4);
    chk(full == 1'b1, "R6 full flag at capacity", full, 1);
    chk(wptr == PW'(12'h800), "R5 wrap toggles phase", wptr, 12'h800);
    check_mem("R4 writes confined to window");

    // R5/R7: software consumes half, refill across the wrap
    rptr = PW'(8);
    @(negedge clk);
    chk(full == 1'b0, "R6 full clears after read pointer moves", full, 0);
    timer = 8'd3;
    push_burst(6);
    settle();
    chk(wptr == PW'(12'h806), "R5 wptr after second lap", wptr, 12'h806);
    check_mem("R5 second lap contents");
    level = PW'(5);
    @(negedge clk);
    chk(lvl == 1'b1, "R7 level above threshold", lvl, 1);
    level = PW'(14);
    @(negedge clk);
    chk(lvl == 1'b0, "R7 level equal to amount is low", lvl, 0);

    // random bursts in a 32-byte window, random timeout and catch-up
    do_reset(40, 47);
    for (int it = 0; it < 40; it++) begin
      timer = 8'($urandom_range(0, 12));
      @(negedge clk);
      push_burst($urandom_range(1, 9));
      settle();
      chk(wptr == exp_wptr(), "R5 random wptr", wptr, exp_wptr());
      chk(lvl == (f_depth(exp_wph, exp_woff, rptr, f_size()) > int'(level)),
          "R7 random level", lvl, 0);
      if ($urandom_range(0, 1) == 1) begin
        rptr = exp_wptr();
        @(negedge clk);
      end
    end
    check_mem("R6 random contents");
    chk(n_ovf == exp_drop, "R6 random drop count", n_ovf, exp_drop);
    chk(head == tail, "R9 every byte popped once", head, tail);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule